// File: doc/BRIEF.md
# Clock-Source Select Register Bank

This block holds one clock-select register for each consumer inside a clock generation unit: the PLL, a set of fractional dividers, two restricted outputs (a fail-safe clock and a power-control clock) and a set of general output generators. Each register's 5-bit select code goes to the clock multiplexers, which are outside this block. Software writes the registers over a simple synchronous bus. Each write is checked against a fixed table of permitted sources for that consumer and against live activity flags for every source. A write that asks for an illegal source, or for a source that is not running, keeps the old select code. The other fields of the same write still take effect, and a sticky error flag records that the write was refused. This way software can never switch a consumer onto a dead or looping clock.

Each of the twelve candidate sources has its own activity monitor, clocked by the register clock. The monitor counts edges of its source over a fixed window and reports the source as running only when enough edges were seen.

Top module: `csel_reg_bank`

## Requirements
- R1: After reset, register 0 (PLL) holds select code 1 and every other register holds code 0; all auxiliary fields and error flags are 0.
- R2: A general output register (index 10 to 13) accepts codes 0, 1, 2, 3, 4 and 8 to 14, provided the source is running.
- R3: The safe-clock register (index 8) and the power-control register (index 9) accept only code 0 and refuse every other code.
- R4: A divider register (index 1 to 7) accepts only codes 0 to 4 and refuses divider codes 8 to 14.
- R5: The PLL register (index 0) accepts only code 1 (crystal) and refuses every other code.
- R6: Codes 5, 6, 7 and 15 to 31 are refused by every register.
- R7: On a refused write, the select field [4:0] keeps its old value while the auxiliary field [15:8] takes the written data in that same write; with no write, select codes never change.
- R8: Source encoding: code 0 is the low-power oscillator, 1 is the crystal, 2 to 4 are the PLL taps, and 8 to 14 are dividers 0 to 6. A source whose monitor has seen fewer than 2 edges in its last 64-cycle window counts as stopped, and a write selecting it is refused.
- R9: Error flag bit 31 is set by every refused write and stays set. It is cleared by an accepted write that has bit 31 = 1. A refused write with bit 31 = 1 leaves the flag set.
- R10: Several registers may hold the same code at once; such sharing raises no error.
- R11: Read data is {err, 15'b0, aux[7:0], 3'b0, sel[4:0]} for the register at rd_addr. An address of 14 or above reads 0, and a write to such an address changes nothing.
- R12: Register indices: 0 is the PLL, 1 to 7 are dividers 0 to 6, 8 is the safe clock, 9 is the power-control clock, and 10 to 13 are the general outputs. Field k of sel_o is bits [5k+4:5k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 2+PLL_TAPS+NUM_DIV (12) | Candidate source clocks, monitored for activity (bit i = source i in code order) |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (5) | Write register index |
| wdata | input | 32 | Write data: sel [4:0], aux [15:8], error clear [31] |
| rd_addr | input | ADDR_W (5) | Read register index |
| rd_data | output | 32 | Read data for rd_addr |
| sel_o | output | NUM_REG*5 (70) | Applied select codes, one 5-bit field per register |

## Verification
The bench targets the boundaries of the permission table: a divider asking for another divider, the PLL asked to take anything but the crystal, the restricted outputs asked to take a PLL tap, and the codes in the gap between 4 and 8 and above 14. A design with a loose table would let those codes reach sel_o. Refused writes carry fresh auxiliary data to expose a design that drops the whole write instead of only the select field. The error flag is written with its clear bit during a refusal to catch a design where clear wins over set. Two sources are stopped and restarted, so a monitor that never drops its flag, or never raises it again, makes writes succeed or fail at the wrong times.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
    localparam int SEL_W   = 5;
    localparam int AUX_W   = 8;
    localparam int AUX_LSB = 8;
    localparam int ERR_BIT = 31;

    localparam int CODE_LPO      = 0;
    localparam int CODE_XTAL     = 1;
    localparam int CODE_PLL_BASE = 2;
    localparam int CODE_DIV_BASE = 8;

    typedef enum logic [1:0] {
        KIND_PLL   = 2'd0,
        KIND_DIV   = 2'd1,
        KIND_RESTR = 2'd2,
        KIND_GEN   = 2'd3
    } csel_kind_e;
endpackage

// File: rtl/csel_act_mon.sv
`timescale 1ns/1ps
module csel_act_mon #(
    parameter int WINDOW    = 64,
    parameter int MIN_EDGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic active
);
    localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int CNT_W = $clog2(MIN_EDGES + 1);

    // toggles once per monitored rising edge; crossed into ref_clk below
    logic tog_q;
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    typedef struct packed {
        logic [2:0]       sync;
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] cnt;
        logic             active;
    } mon_t;

    mon_t mon_d, mon_q;
    logic edge_seen;
    logic [CNT_W:0] total;

    always_comb begin
        mon_d      = mon_q;
        mon_d.sync = {mon_q.sync[1:0], tog_q};
        edge_seen  = mon_q.sync[2] ^ mon_q.sync[1];
        total      = {1'b0, mon_q.cnt} + (CNT_W+1)'(edge_seen);
        if (mon_q.win == WIN_W'(WINDOW - 1)) begin
            mon_d.win    = '0;
            mon_d.cnt    = '0;
            mon_d.active = (total >= (CNT_W+1)'(MIN_EDGES));
        end else begin
            mon_d.win = mon_q.win + 1'b1;
            mon_d.cnt = (total >= (CNT_W+1)'(MIN_EDGES)) ? CNT_W'(MIN_EDGES)
                                                         : total[CNT_W-1:0];
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign active = mon_q.active;
endmodule

// File: rtl/csel_src_check.sv
`timescale 1ns/1ps
module csel_src_check
    import csel_pkg::*;
#(
    parameter int NUM_DIV  = 7,
    parameter int PLL_TAPS = 3
) (
    input  csel_kind_e                      kind,
    input  logic [SEL_W-1:0]                code,
    input  logic [2+PLL_TAPS+NUM_DIV-1:0]   src_active,
    output logic                            ok
);
    localparam int NSRC    = 2 + PLL_TAPS + NUM_DIV;
    localparam int PLL_END = CODE_PLL_BASE + PLL_TAPS;

    logic [NSRC-1:0] hit;
    logic is_osc, is_pll, is_div, legal;
    int   code_i;

    always_comb begin
        code_i = int'(code);
        is_osc = (code_i == CODE_LPO) || (code_i == CODE_XTAL);
        is_pll = (code_i >= CODE_PLL_BASE) && (code_i < PLL_END);
        is_div = (code_i >= CODE_DIV_BASE) && (code_i < CODE_DIV_BASE + NUM_DIV);
        unique case (kind)
            KIND_PLL:   legal = (code_i == CODE_XTAL);
            KIND_RESTR: legal = (code_i == CODE_LPO);
            KIND_DIV:   legal = is_osc || is_pll;
            default:    legal = is_osc || is_pll || is_div;
        endcase
        for (int k = 0; k < NSRC; k++) begin
            hit[k] = (k < PLL_END) ? (code_i == k)
                                   : (code_i == k - PLL_END + CODE_DIV_BASE);
        end
        ok = legal && (|(hit & src_active));
    end
endmodule

// File: rtl/csel_reg_bank.sv
`timescale 1ns/1ps
module csel_reg_bank
    import csel_pkg::*;
#(
    parameter int NUM_DIV       = 7,
    parameter int NUM_GEN       = 4,
    parameter int PLL_TAPS      = 3,
    parameter int ADDR_W        = 5,
    parameter int ACT_WINDOW    = 64,
    parameter int ACT_MIN_EDGES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [2+PLL_TAPS+NUM_DIV-1:0]       src_clk,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [31:0]                         wdata,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [31:0]                         rd_data,
    output logic [(NUM_DIV+NUM_GEN+3)*SEL_W-1:0] sel_o
);
    localparam int NSRC      = 2 + PLL_TAPS + NUM_DIV;
    localparam int NUM_REG   = NUM_DIV + NUM_GEN + 3;
    localparam int IDX_SAFE  = NUM_DIV + 1;
    localparam int IDX_PCTL  = NUM_DIV + 2;

    // activity monitors, one per source
    logic [NSRC-1:0] src_active;
    for (genvar s = 0; s < NSRC; s++) begin : g_mon
        csel_act_mon #(
            .WINDOW    (ACT_WINDOW),
            .MIN_EDGES (ACT_MIN_EDGES)
        ) u_mon (
            .ref_clk (clk),
            .rst_n   (rst_n),
            .mon_clk (src_clk[s]),
            .active  (src_active[s])
        );
    end

    function automatic csel_kind_e kind_of(input int idx);
        if (idx == 0)                               return KIND_PLL;
        else if (idx <= NUM_DIV)                    return KIND_DIV;
        else if (idx == IDX_SAFE || idx == IDX_PCTL) return KIND_RESTR;
        else                                        return KIND_GEN;
    endfunction

    typedef struct packed {
        logic [NUM_REG-1:0][SEL_W-1:0] sel;
        logic [NUM_REG-1:0][AUX_W-1:0] aux;
        logic [NUM_REG-1:0]            err;
    } bank_t;

    bank_t      bank_d, bank_q;
    csel_kind_e wr_kind;
    logic       sel_ok;
    int         wr_idx;

    assign wr_idx  = int'(addr);
    assign wr_kind = kind_of(wr_idx);

    csel_src_check #(
        .NUM_DIV  (NUM_DIV),
        .PLL_TAPS (PLL_TAPS)
    ) u_check (
        .kind       (wr_kind),
        .code       (wdata[SEL_W-1:0]),
        .src_active (src_active),
        .ok         (sel_ok)
    );

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            for (int r = 0; r < NUM_REG; r++) begin
                if (r == wr_idx) begin
                    bank_d.aux[r] = wdata[AUX_LSB +: AUX_W];
                    if (sel_ok) begin
                        bank_d.sel[r] = wdata[SEL_W-1:0];
                        bank_d.err[r] = bank_q.err[r] & ~wdata[ERR_BIT];
                    end else begin
                        bank_d.err[r] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q        <= '0;
            bank_q.sel[0] <= SEL_W'(CODE_XTAL);
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REG; r++) begin
            if (r == int'(rd_addr)) begin
                rd_data = {bank_q.err[r], 15'b0, bank_q.aux[r], 3'b0, bank_q.sel[r]};
            end
        end
    end

    assign sel_o = bank_q.sel;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[30:16], wdata[7:5]};
endmodule

// File: rtl/csel_reg_bank_chk.sv
`timescale 1ns/1ps
module csel_reg_bank_chk
    import csel_pkg::*;
#(
    parameter int NUM_DIV  = 7,
    parameter int NUM_GEN  = 4,
    parameter int PLL_TAPS = 3,
    parameter int ADDR_W   = 5
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 wr_en,
    input logic [ADDR_W-1:0]                    addr,
    input logic [SEL_W-1:0]                     wr_code,
    input logic [(NUM_DIV+NUM_GEN+3)*SEL_W-1:0] sel_o
);
    localparam int NUM_REG = NUM_DIV + NUM_GEN + 3;
    localparam int PLL_END = CODE_PLL_BASE + PLL_TAPS;

    logic undef_code;
    assign undef_code = ((int'(wr_code) >= PLL_END) && (int'(wr_code) < CODE_DIV_BASE))
                     || (int'(wr_code) >= CODE_DIV_BASE + NUM_DIV);

    // R5
    pll_xtal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_o[SEL_W-1:0]) == CODE_XTAL);

    // R3
    safe_lpo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_o[(NUM_DIV+1)*SEL_W +: SEL_W]) == CODE_LPO);

    // R3
    pctl_lpo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_o[(NUM_DIV+2)*SEL_W +: SEL_W]) == CODE_LPO);

    for (genvar d = 1; d <= NUM_DIV; d++) begin : g_div
        // R4
        div_no_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(sel_o[d*SEL_W +: SEL_W]) < PLL_END);
    end

    // R6
    undef_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && undef_code) |=> $stable(sel_o));

    // R11
    bad_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) >= NUM_REG) |=> $stable(sel_o));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_o));
endmodule

bind csel_reg_bank csel_reg_bank_chk #(
    .NUM_DIV  (NUM_DIV),
    .NUM_GEN  (NUM_GEN),
    .PLL_TAPS (PLL_TAPS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_code (wdata[4:0]),
    .sel_o   (sel_o)
);

// File: tb/csel_reg_bank_bench.sv
`timescale 1ns/1ps
module csel_reg_bank_bench;
    localparam int NREG = 14;
    localparam int NSRC = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_clk = '0;
    logic [NSRC-1:0]   src_run = '1;
    logic              wr_en = 1'b0;
    logic [4:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [4:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic [NREG*5-1:0] sel_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    int       m_sel [NREG];
    logic [7:0] m_aux [NREG];
    logic     m_err [NREG];

    csel_reg_bank u_csel_reg_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_clk (src_clk),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sel_o   (sel_o)
    );

    always #10 clk = ~clk;

    // source clocks: half-periods of 40..70 ns, each gated by src_run
    initial begin
        int cnt [NSRC];
        for (int g = 0; g < NSRC; g++) cnt[g] = 4 + g % 4;
        #3;
        forever begin
            #10;
            for (int g = 0; g < NSRC; g++) begin
                if (src_run[g]) begin
                    cnt[g]--;
                    if (cnt[g] == 0) begin
                        src_clk[g] = ~src_clk[g];
                        cnt[g] = 4 + g % 4;
                    end
                end
            end
        end
    end

    function automatic void model_reset();
        for (int i = 0; i < NREG; i++) begin
            m_sel[i] = (i == 0) ? 1 : 0;
            m_aux[i] = 8'h00;
            m_err[i] = 1'b0;
        end
    endfunction

    // permission table and activity, taken from R2..R6 and R8
    function automatic bit model_ok(int idx, int code);
        int s;
        s = -1;
        if (code >= 0 && code <= 4) s = code;
        else if (code >= 8 && code <= 14) s = code - 3;
        if (s < 0) return 1'b0;
        if (!src_run[s]) return 1'b0;
        if (idx == 0) return code == 1;
        if (idx <= 7) return code <= 4;
        if (idx == 8 || idx == 9) return code == 0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] model_rd(int idx);
        if (idx >= NREG) return 32'h0;
        return {m_err[idx], 15'b0, m_aux[idx], 3'b0, m_sel[idx][4:0]};
    endfunction

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                n_checks++;
                if (int'(sel_o[i*5 +: 5]) != m_sel[i]) begin
                    n_fail++;
                    $display("FAIL %s: sel_o field %0d = %0d, expected %0d",
                             cur_req, i, sel_o[i*5 +: 5], m_sel[i]);
                end
            end
            n_checks++;
            if (rd_data !== model_rd(int'(rd_addr))) begin
                n_fail++;
                $display("FAIL %s: rd_data @%0d = %h, expected %h",
                         cur_req, rd_addr, rd_data, model_rd(int'(rd_addr)));
            end
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_addr = 5'((int'(rd_addr) + 1) % (NREG + 2));
        end
    endtask

    task automatic wr(int idx, int code, logic [7:0] aux, logic clr);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 5'(idx);
        wdata = {clr, 15'b0, aux, 3'b0, 5'(code)};
        @(posedge clk);
        if (idx < NREG) begin
            m_aux[idx] = aux;
            if (model_ok(idx, code)) begin
                m_sel[idx] = code;
                m_err[idx] = m_err[idx] & ~clr;
            end else begin
                m_err[idx] = 1'b1;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // explicit check with literal expectations
    task automatic chk(string req, int idx, int e_sel, logic [7:0] e_aux, logic e_err);
        logic [31:0] exp_v;
        @(negedge clk);
        rd_addr = 5'(idx);
        #1;
        exp_v = (idx >= NREG) ? 32'h0 : {e_err, 15'b0, e_aux, 3'b0, 5'(e_sel)};
        n_checks++;
        if (rd_data !== exp_v) begin
            n_fail++;
            $display("FAIL %s: reg %0d read %h, expected %h", req, idx, rd_data, exp_v);
        end
    endtask

    initial begin
        model_reset();
        #95;
        rst_n = 1'b1;

        // R1 reset state, R12 index layout via sel_o
        cur_req = "R1";
        chk("R1", 0, 1, 8'h00, 1'b0);
        chk("R1", 8, 0, 8'h00, 1'b0);
        chk("R1", 13, 0, 8'h00, 1'b0);
        n_checks++;
        if (sel_o !== 70'd1) begin
            n_fail++;
            $display("FAIL R12: sel_o after reset %h, expected %h", sel_o, 70'd1);
        end

        idle(300);

        cur_req = "R2";
        wr(10, 4, 8'h11, 1'b0);  chk("R2", 10, 4, 8'h11, 1'b0);
        wr(10, 14, 8'h22, 1'b0); chk("R2", 10, 14, 8'h22, 1'b0);
        wr(10, 8, 8'h33, 1'b0);  chk("R2", 10, 8, 8'h33, 1'b0);
        wr(10, 1, 8'h44, 1'b0);  chk("R2", 10, 1, 8'h44, 1'b0);

        cur_req = "R10";
        wr(11, 1, 8'h55, 1'b0);  chk("R10", 11, 1, 8'h55, 1'b0);
        wr(1, 1, 8'h66, 1'b0);   chk("R10", 1, 1, 8'h66, 1'b0);
        chk("R10", 10, 1, 8'h44, 1'b0);

        cur_req = "R3";
        wr(8, 1, 8'h77, 1'b0);   chk("R3 R7", 8, 0, 8'h77, 1'b1);
        wr(9, 2, 8'h12, 1'b0);   chk("R3", 9, 0, 8'h12, 1'b1);
        wr(8, 0, 8'h78, 1'b1);   chk("R3 R9", 8, 0, 8'h78, 1'b0);

        cur_req = "R4";
        wr(2, 9, 8'h21, 1'b0);   chk("R4 R7", 2, 0, 8'h21, 1'b1);
        wr(2, 3, 8'h22, 1'b0);   chk("R4 R9", 2, 3, 8'h22, 1'b1);
        wr(2, 3, 8'h23, 1'b1);   chk("R9", 2, 3, 8'h23, 1'b0);

        cur_req = "R5";
        wr(0, 0, 8'h31, 1'b0);   chk("R5", 0, 1, 8'h31, 1'b1);
        wr(0, 2, 8'h32, 1'b1);   chk("R5 R9", 0, 1, 8'h32, 1'b1);
        wr(0, 1, 8'h33, 1'b1);   chk("R5", 0, 1, 8'h33, 1'b0);

        cur_req = "R6";
        wr(12, 5, 8'h05, 1'b0);  chk("R6", 12, 0, 8'h05, 1'b1);
        wr(12, 7, 8'h07, 1'b0);  chk("R6", 12, 0, 8'h07, 1'b1);
        wr(12, 15, 8'h0f, 1'b0); chk("R6", 12, 0, 8'h0f, 1'b1);
        wr(12, 31, 8'h1f, 1'b0); chk("R6", 12, 0, 8'h1f, 1'b1);
        wr(12, 13, 8'h00, 1'b1); chk("R6", 12, 13, 8'h00, 1'b0);

        cur_req = "R11";
        wr(20, 2, 8'hff, 1'b1);
        chk("R11", 20, 0, 8'h00, 1'b0);
        chk("R11", 13, 0, 8'h00, 1'b0);

        // R8: stop crystal (source 1) and divider 3 (code 11, source 8)
        cur_req = "R8";
        src_run[1] = 1'b0;
        src_run[8] = 1'b0;
        idle(300);
        wr(13, 11, 8'h41, 1'b0); chk("R8", 13, 0, 8'h41, 1'b1);
        wr(13, 1, 8'h42, 1'b0);  chk("R8", 13, 0, 8'h42, 1'b1);
        wr(0, 1, 8'h43, 1'b0);   chk("R8", 0, 1, 8'h43, 1'b1);
        wr(5, 1, 8'h44, 1'b0);   chk("R8", 5, 0, 8'h44, 1'b1);
        wr(13, 2, 8'h45, 1'b1);  chk("R8", 13, 2, 8'h45, 1'b0);
        src_run[1] = 1'b1;
        src_run[8] = 1'b1;
        idle(300);
        wr(13, 11, 8'h46, 1'b0); chk("R8", 13, 11, 8'h46, 1'b0);
        wr(5, 1, 8'h47, 1'b1);   chk("R8", 5, 1, 8'h47, 1'b0);

        idle(20);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule